// File: doc/BRIEF.md
# Channel command stream decoder

This block sits behind a channel command FIFO and classifies a stream of 32-bit command words. Each word is accepted with a valid/ready handshake. A word that arrives while no data words are outstanding is treated as an opcode word. The block decodes its fields and works out how many data words belong to it. The words that follow are then tagged as data words of that command, one by one, until the count runs out. The next word after that is again an opcode word.

The number of data words depends on the opcode:

- the population count of a 6-bit or 16-bit mask;
- a 16-bit count field in the word;
- a fixed count of one or two address words;
- a value stored earlier by a separate payload command.

The payload value is held in a register that resets to an all-ones invalid marker.

Each accepted word gives exactly one registered pulse in the next cycle. An opcode word gives an opcode pulse carrying every decoded field, plus an error flag for undefined opcodes and sub-operations. A data word gives a data pulse carrying the word and its index inside the current command. Downstream logic uses these pulses to perform register writes, lock handling and gather fetches; none of that is done here.

Top module: `cmd_stream_decoder`

## Requirements
- R1: After reset no pulse is raised, `in_ready` rises one cycle after reset is released, and the first accepted word is taken as an opcode word.
- R2: The opcode is bits 31:28 of an opcode word. Each accepted word gives exactly one pulse in the following cycle: `op_valid` for an opcode word, `data_valid` for a data word. `op_code` repeats bits 31:28, and `op_ndata` gives the number of data words that follow.
- R3: Opcode 0 (set-class) reports offset bits 27:16, class bits 15:6 and mask bits 5:0. It is followed by one data word per set bit of that 6-bit mask.
- R4: Opcodes 1 and 2 (increment and non-increment write) report offset bits 27:16 and take bits 15:0 as the data-word count. A count of zero makes the next word an opcode word.
- R5: Opcode 3 (masked write) reports offset bits 27:16 and mask bits 15:0. It is followed by as many data words as that mask has set bits.
- R6: Opcode 4 (immediate) reports offset bits 27:16 and data bits 15:0. Opcode 5 (restart) reports the word shifted left by 4, truncated to 32 bits. Neither has data words.
- R7: Opcode 6 (gather) reports offset 27:16, insert flag bit 15, type flag bit 14 and count 13:0, and is followed by one data word. Opcode 12 (wide gather) reports count 13:0 and is followed by two data words.
- R8: Opcode 7 reports a stream ID from bits 21:0, opcode 8 reports an application ID from bits 7:0, and opcode 9 stores bits 15:0 as the payload. None of them has data words.
- R9: Opcodes 10 and 11 (wide writes) report a 22-bit offset from bits 21:0. Their data-word count is the stored payload. The count is zero when the payload is 0 or 0xFFFF, and 0xFFFF is the reset value.
- R10: Opcode 14 (extend) reports sub-operation bits 27:24 and lock index bits 7:0. Sub-operation 0 is acquire and 1 is release; any other sub-operation raises `err_valid` with the opcode pulse and has no data words.
- R11: Opcodes 13 and 15 raise `err_valid` with the opcode pulse and have no data words.
- R12: A data pulse carries the accepted word on `data_word` and its index on `data_index`. The index counts from 0 and rises by one for each data word of the same command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_word | input | 32 | Command word |
| in_ready | output | 1 | Block accepts words |
| op_valid | output | 1 | Opcode word decoded (one-cycle pulse) |
| op_code | output | 4 | Opcode value |
| op_offset | output | 22 | Register offset (12 bits for narrow opcodes, 22 for wide writes) |
| op_class | output | 10 | Class ID of set-class |
| op_mask | output | 16 | Mask of set-class or masked write |
| op_imm | output | 16 | Immediate data or set-payload value |
| op_id | output | 22 | Stream ID or application ID |
| op_restart_addr | output | 32 | Restart address |
| op_gather_insert | output | 1 | Gather insert flag |
| op_gather_type | output | 1 | Gather type flag |
| op_gather_count | output | 14 | Gather word count |
| op_subop | output | 4 | Extend sub-operation |
| op_lock_idx | output | 8 | Lock index of extend |
| op_ndata | output | 16 | Data words following this opcode |
| err_valid | output | 1 | Unknown opcode or sub-operation (with op_valid) |
| data_valid | output | 1 | Data word accepted (one-cycle pulse) |
| data_word | output | 32 | Data word |
| data_index | output | 16 | Position of the data word within its command |

## Verification
Each opcode is sent with a data tail that is either empty or non-empty. The bench then sends a marker opcode after the tail, so a wrong count shows up as a word being misclassified.

The mask patterns are chosen so that a population count, a raw field value and a fixed count would give different answers. Examples are a sparse 6-bit mask and a 16-bit mask with nine bits set.

The wide writes are tried in three payload states: before any payload is set, after a real value, and after the all-ones marker. This separates the stored-count path from the invalid marker. Extend sub-operations 0, 1 and 7, and opcodes 13 and 15, exercise the error flag.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  localparam int CMD_W = 32;
  localparam int CNT_W = 16;

  typedef enum logic [3:0] {
    OP_SETCLS  = 4'd0,
    OP_WR_INC  = 4'd1,
    OP_WR_FIX  = 4'd2,
    OP_WR_MSK  = 4'd3,
    OP_IMMED   = 4'd4,
    OP_RESTART = 4'd5,
    OP_GATHER  = 4'd6,
    OP_STREAM  = 4'd7,
    OP_APPID   = 4'd8,
    OP_PAYLOAD = 4'd9,
    OP_WWR_INC = 4'd10,
    OP_WWR_FIX = 4'd11,
    OP_WGATHER = 4'd12,
    OP_EXTEND  = 4'd14
  } opc_e;

  typedef struct packed {
    logic [3:0]       code;
    logic [21:0]      offset;
    logic [9:0]       cls;
    logic [15:0]      mask;
    logic [15:0]      imm;
    logic [21:0]      id;
    logic [31:0]      raddr;
    logic             g_insert;
    logic             g_type;
    logic [13:0]      g_count;
    logic [3:0]       subop;
    logic [7:0]       lock_idx;
    logic [CNT_W-1:0] ndata;
    logic             bad;
    logic             set_pay;
  } dec_t;

  function automatic logic [CNT_W-1:0] bits_set(input logic [15:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < 16; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] payload_words(input logic [15:0] p);
    return (p == 16'hFFFF) ? '0 : CNT_W'(p);
  endfunction

endpackage

// File: rtl/cmd_field_extract.sv
module cmd_field_extract
  import cmd_dec_pkg::*;
(
  input  logic [CMD_W-1:0] word,
  input  logic [15:0]      payload,
  output dec_t             dec
);
  always_comb begin
    dec          = '0;
    dec.code     = word[31:28];
    dec.offset   = {10'd0, word[27:16]};
    dec.cls      = word[15:6];
    dec.imm      = word[15:0];
    dec.raddr    = {word[27:0], 4'd0};
    dec.g_insert = word[15];
    dec.g_type   = word[14];
    dec.g_count  = word[13:0];
    dec.subop    = word[27:24];
    dec.lock_idx = word[7:0];
    unique case (word[31:28])
      OP_SETCLS: begin
        dec.mask  = {10'd0, word[5:0]};
        dec.ndata = bits_set({10'd0, word[5:0]});
      end
      OP_WR_INC, OP_WR_FIX: dec.ndata = word[15:0];
      OP_WR_MSK: begin
        dec.mask  = word[15:0];
        dec.ndata = bits_set(word[15:0]);
      end
      OP_IMMED, OP_RESTART: dec.ndata = '0;
      OP_GATHER:  dec.ndata = CNT_W'(1);
      OP_WGATHER: dec.ndata = CNT_W'(2);
      OP_STREAM:  dec.id = word[21:0];
      OP_APPID:   dec.id = {14'd0, word[7:0]};
      OP_PAYLOAD: dec.set_pay = 1'b1;
      OP_WWR_INC, OP_WWR_FIX: begin
        dec.offset = word[21:0];
        dec.ndata  = payload_words(payload);
      end
      OP_EXTEND:  dec.bad = (word[27:24] > 4'd1);
      default:    dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/cmd_payload_reg.sv
module cmd_payload_reg #(
  parameter logic [15:0] INVALID = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [15:0] value,
  output logic [15:0] payload
);
  always_ff @(posedge clk) begin
    if (!rst_n)    payload <= INVALID;
    else if (load) payload <= value;
  end
endmodule

// File: rtl/cmd_word_tracker.sv
module cmd_word_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CNT_W-1:0] load_count,
  output logic             at_opcode,
  output logic [CNT_W-1:0] remaining,
  output logic [CNT_W-1:0] index
);
  assign at_opcode = (remaining == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      index     <= '0;
    end else if (accept) begin
      if (at_opcode) begin
        remaining <= load_count;
        index     <= '0;
      end else begin
        remaining <= remaining - 1'b1;
        index     <= index + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter logic [15:0] PAYLOAD_INVALID = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_word,
  output logic        in_ready,
  output logic        op_valid,
  output logic [3:0]  op_code,
  output logic [21:0] op_offset,
  output logic [9:0]  op_class,
  output logic [15:0] op_mask,
  output logic [15:0] op_imm,
  output logic [21:0] op_id,
  output logic [31:0] op_restart_addr,
  output logic        op_gather_insert,
  output logic        op_gather_type,
  output logic [13:0] op_gather_count,
  output logic [3:0]  op_subop,
  output logic [7:0]  op_lock_idx,
  output logic [15:0] op_ndata,
  output logic        err_valid,
  output logic        data_valid,
  output logic [31:0] data_word,
  output logic [15:0] data_index
);
  logic             accept;
  logic             at_opcode;
  logic             op_accept;
  logic             data_accept;
  logic [15:0]      payload;
  logic [CNT_W-1:0] remaining;
  logic [CNT_W-1:0] index;
  dec_t             dec;
  dec_t             dec_q;

  assign accept      = in_valid && in_ready;
  assign op_accept   = accept && at_opcode;
  assign data_accept = accept && !at_opcode;

  cmd_field_extract u_extract (
    .word    (in_word),
    .payload (payload),
    .dec     (dec)
  );

  cmd_payload_reg #(.INVALID(PAYLOAD_INVALID)) u_payload (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (op_accept && dec.set_pay),
    .value   (in_word[15:0]),
    .payload (payload)
  );

  cmd_word_tracker #(.CNT_W(CNT_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .load_count (dec.ndata),
    .at_opcode  (at_opcode),
    .remaining  (remaining),
    .index      (index)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready   <= 1'b0;
      op_valid   <= 1'b0;
      err_valid  <= 1'b0;
      data_valid <= 1'b0;
      dec_q      <= '0;
      data_word  <= '0;
      data_index <= '0;
    end else begin
      in_ready   <= 1'b1;
      op_valid   <= op_accept;
      err_valid  <= op_accept && dec.bad;
      data_valid <= data_accept;
      if (op_accept) dec_q <= dec;
      if (data_accept) begin
        data_word  <= in_word;
        data_index <= index;
      end
    end
  end

  assign op_code          = dec_q.code;
  assign op_offset        = dec_q.offset;
  assign op_class         = dec_q.cls;
  assign op_mask          = dec_q.mask;
  assign op_imm           = dec_q.imm;
  assign op_id            = dec_q.id;
  assign op_restart_addr  = dec_q.raddr;
  assign op_gather_insert = dec_q.g_insert;
  assign op_gather_type   = dec_q.g_type;
  assign op_gather_count  = dec_q.g_count;
  assign op_subop         = dec_q.subop;
  assign op_lock_idx      = dec_q.lock_idx;
  assign op_ndata         = dec_q.ndata;
endmodule

// File: rtl/cmd_stream_decoder_sva.sv
module cmd_stream_decoder_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        at_opcode,
  input logic        op_valid,
  input logic        err_valid,
  input logic        data_valid,
  input logic [15:0] data_index
);
  a_r2_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (op_valid ^ data_valid));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !(op_valid || data_valid));

  a_r2_opcode_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && at_opcode) |=> op_valid);

  a_r12_data_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !at_opcode) |=> data_valid);

  a_r12_index_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && data_index != 16'd0) |-> $past(data_valid || !(in_valid && in_ready)) || $past(!op_valid));

  a_r10_err_with_op: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> op_valid);

  a_r1_ready_after_reset: assert property (@(posedge clk)
    !rst_n |=> !in_ready && !op_valid && !data_valid);
endmodule

bind cmd_stream_decoder cmd_stream_decoder_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .at_opcode  (at_opcode),
  .op_valid   (op_valid),
  .err_valid  (err_valid),
  .data_valid (data_valid),
  .data_index (data_index)
);

// File: tb/tb_cmd_stream_decoder.sv
module tb_cmd_stream_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        in_ready;
  logic        op_valid, op_gather_insert, op_gather_type, err_valid, data_valid;
  logic [3:0]  op_code, op_subop;
  logic [21:0] op_offset, op_id;
  logic [9:0]  op_class;
  logic [15:0] op_mask, op_imm, op_ndata, data_index;
  logic [31:0] op_restart_addr, data_word;
  logic [13:0] op_gather_count;
  logic [7:0]  op_lock_idx;

  int checks = 0;
  int fails  = 0;
  logic [15:0] pay_model = 16'hFFFF;

  always #2 clk = ~clk;

  cmd_stream_decoder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
    .op_valid(op_valid), .op_code(op_code), .op_offset(op_offset), .op_class(op_class),
    .op_mask(op_mask), .op_imm(op_imm), .op_id(op_id), .op_restart_addr(op_restart_addr),
    .op_gather_insert(op_gather_insert), .op_gather_type(op_gather_type),
    .op_gather_count(op_gather_count), .op_subop(op_subop), .op_lock_idx(op_lock_idx),
    .op_ndata(op_ndata), .err_valid(err_valid), .data_valid(data_valid),
    .data_word(data_word), .data_index(data_index)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int ones(input logic [15:0] v);
    int n = 0;
    for (int i = 0; i < 16; i++) if (v[i]) n++;
    return n;
  endfunction

  // Expected tail length, restated from R3..R11.
  function automatic int tail_len(input logic [31:0] w);
    case (w[31:28])
      4'd0:          return ones({10'd0, w[5:0]});
      4'd1, 4'd2:    return int'(w[15:0]);
      4'd3:          return ones(w[15:0]);
      4'd6:          return 1;
      4'd12:         return 2;
      4'd10, 4'd11:  return (pay_model == 16'hFFFF) ? 0 : int'(pay_model);
      default:       return 0;
    endcase
  endfunction

  // Sends an opcode, its data tail and a marker; checks the count and every data pulse.
  task automatic run_cmd(input logic [31:0] w, input string req);
    int n;
    n = tail_len(w);
    send(w);
    chk(op_valid && !data_valid, req, {31'd0, op_valid}, 32'd1);
    chk(op_code == w[31:28], req, {28'd0, op_code}, {28'd0, w[31:28]});
    chk(int'(op_ndata) == n, req, {16'd0, op_ndata}, n);
    if (w[31:28] == 4'd9) pay_model = w[15:0];
    for (int i = 0; i < n; i++) begin
      send(32'hD000_0000 + i);
      chk(data_valid && !op_valid, "R12", {31'd0, data_valid}, 32'd1);
      chk(data_word == 32'hD000_0000 + i && int'(data_index) == i, "R12",
          {data_index, data_word[15:0]}, {i[15:0], i[15:0]});
    end
  endtask

  task automatic marker(input string req);
    send(32'h4123_0042);
    chk(op_valid && op_code == 4'd4, req, {28'd0, op_code}, 32'd4);
  endtask

  task automatic t_reset;
    chk(!op_valid && !data_valid && !err_valid, "R1", {29'd0, op_valid, data_valid, err_valid}, 0);
    @(negedge clk);
    chk(in_ready, "R1", {31'd0, in_ready}, 1);
    marker("R1");
  endtask

  task automatic t_setclass;
    logic [31:0] w = {4'd0, 12'h3A5, 10'h2C7, 6'b101001};
    run_cmd(w, "R3");
    send(w); // re-send to inspect fields
    chk(op_offset == 22'h3A5 && op_class == 10'h2C7 && op_mask == 16'h29, "R3",
        {op_offset[11:0], op_class, op_mask[9:0]}, {12'h3A5, 10'h2C7, 10'h29});
    for (int i = 0; i < 3; i++) send(32'hD000_0000);
    run_cmd({4'd0, 12'h001, 10'h001, 6'd0}, "R3");
    marker("R3");
  endtask

  task automatic t_writes;
    run_cmd({4'd1, 12'h010, 16'd3}, "R4");
    chk(op_offset == 22'h010, "R4", {10'd0, op_offset}, 32'h10);
    run_cmd({4'd2, 12'h020, 16'd0}, "R4");
    marker("R4");
    run_cmd({4'd3, 12'h030, 16'hF0F1}, "R5");
    chk(op_mask == 16'hF0F1, "R5", {16'd0, op_mask}, 32'hF0F1);
    marker("R5");
  endtask

  task automatic t_imm_restart;
    run_cmd({4'd4, 12'h777, 16'hBEEF}, "R6");
    chk(op_offset == 22'h777 && op_imm == 16'hBEEF, "R6", {op_offset[11:0], op_imm}, 32'h777BEEF);
    run_cmd(32'h5ABC_DEF1, "R6");
    chk(op_restart_addr == (32'h5ABC_DEF1 << 4), "R6", op_restart_addr, 32'h5ABC_DEF1 << 4);
    marker("R6");
  endtask

  task automatic t_gather;
    run_cmd({4'd6, 12'h0AB, 1'b1, 1'b0, 14'h1234}, "R7");
    chk(op_gather_insert && !op_gather_type && op_gather_count == 14'h1234, "R7",
        {16'd0, op_gather_insert, op_gather_type, op_gather_count}, {16'd0, 2'b10, 14'h1234});
    run_cmd({4'd12, 14'd0, 14'h0077}, "R7");
    chk(op_gather_count == 14'h0077, "R7", {18'd0, op_gather_count}, 32'h77);
    marker("R7");
  endtask

  task automatic t_ids_payload;
    run_cmd({4'd7, 6'd0, 22'h2ABCDE}, "R8");
    chk(op_id == 22'h2ABCDE, "R8", {10'd0, op_id}, 32'h2ABCDE);
    run_cmd({4'd8, 20'hFFFFF, 8'h9C}, "R8");
    chk(op_id == 22'h9C, "R8", {10'd0, op_id}, 32'h9C);
  endtask

  task automatic t_wide;
    run_cmd({4'd10, 6'd0, 22'h3F0001}, "R9"); // payload never set
    chk(op_offset == 22'h3F0001, "R9", {10'd0, op_offset}, 32'h3F0001);
    marker("R9");
    run_cmd({4'd9, 12'd0, 16'd4}, "R8");
    run_cmd({4'd11, 6'd0, 22'h000123}, "R9");
    marker("R9");
    run_cmd({4'd9, 12'd0, 16'd0}, "R8");
    run_cmd({4'd10, 6'd0, 22'h1}, "R9");
    marker("R9");
    run_cmd({4'd9, 12'd0, 16'hFFFF}, "R8");
    run_cmd({4'd11, 6'd0, 22'h2}, "R9");
    marker("R9");
  endtask

  task automatic t_extend_unknown;
    run_cmd({4'd14, 4'd0, 16'd0, 8'h5A}, "R10");
    chk(!err_valid && op_subop == 4'd0 && op_lock_idx == 8'h5A, "R10",
        {23'd0, err_valid, op_lock_idx}, 32'h5A);
    run_cmd({4'd14, 4'd1, 16'd0, 8'h03}, "R10");
    chk(!err_valid && op_subop == 4'd1, "R10", {27'd0, err_valid, op_subop}, 1);
    run_cmd({4'd14, 4'd7, 24'd0}, "R10");
    chk(err_valid, "R10", {31'd0, err_valid}, 1);
    marker("R10");
    run_cmd({4'd13, 28'h0000010}, "R11");
    chk(err_valid, "R11", {31'd0, err_valid}, 1);
    run_cmd({4'd15, 28'hFFFFFFF}, "R11");
    chk(err_valid, "R11", {31'd0, err_valid}, 1);
    marker("R11");
    chk(!err_valid, "R11", {31'd0, err_valid}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setclass();
    t_writes();
    t_imm_restart();
    t_gather();
    t_ids_payload();
    t_wide();
    t_extend_unknown();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule